// File: doc/BRIEF.md
# Compressed Quadrant-0 Instruction Expander

This combinational block turns a 16-bit compressed RISC-V instruction from quadrant 0 into the 32-bit base instruction that does the same work. Quadrant 0 holds the stack-pointer-relative add-immediate and the loads and stores that use compact register specifiers. Each of these formats scatters its scaled immediate across the instruction word in a permuted order. The expander puts that immediate back together and maps each 3-bit register field onto x8..x15. It then emits the base encoding, which a normal 32-bit decoder consumes.

A parameter sets the register width to 32 or 64 bits. Two funct3 slots, 011 and 111, change meaning with that width: on RV32 they are single-precision floating-point word accesses, and on RV64 they are doubleword integer accesses.

Reserved encodings raise `illegal`. Halfwords whose low two bits are not 00 raise `not_q0`. In both cases the expanded word is forced to zero.

Top module: `rvc_q0_expander`

## Requirements
- R1: When `c_instr[1:0]` is not 00, `not_q0` is 1, `illegal` is 0 and `x_instr` is 0. Otherwise `not_q0` is 0.
- R2: A compact register field value v, taken from bits [4:2] (rd'/rs2') or bits [9:7] (rs1'), names register 8+v. It lands in the standard field position of the expanded word: rd at [11:7], rs1 at [19:15], rs2 at [24:20].
- R3: funct3 (bits [15:13]) 000 with a nonzero immediate expands to an add-immediate: opcode 0010011, funct3 000, rs1=x2, rd=rd'. Its immediate is imm[9:6]=c[10:7], imm[5:4]=c[12:11], imm[3]=c[5], imm[2]=c[6], imm[1:0]=0, zero-extended into bits [31:20].
- R4: funct3 000 with a zero immediate is reserved: `illegal` is 1. This includes the all-zero halfword.
- R5: funct3 100 is reserved: `illegal` is 1.
- R6: funct3 010 expands to a word load: opcode 0000011, funct3 010. It uses the word offset imm[6]=c[5], imm[5:3]=c[12:10], imm[2]=c[6], imm[1:0]=0, placed in bits [31:20].
- R7: funct3 110 expands to a word store: opcode 0100011, funct3 010, with the word offset. imm[11:5] goes in bits [31:25] and imm[4:0] goes in bits [11:7].
- R8: funct3 001 expands to a floating-point doubleword load: opcode 0000111, funct3 011. It uses the doubleword offset imm[7:6]=c[6:5], imm[5:3]=c[12:10], imm[2:0]=0.
- R9: funct3 101 expands to a floating-point doubleword store: opcode 0100111, funct3 011, with the doubleword offset in store layout.
- R10: funct3 011 depends on `XLEN`. With XLEN=32 it becomes a floating-point word load (opcode 0000111, funct3 010, word offset). With XLEN=64 it becomes an integer doubleword load (opcode 0000011, funct3 011, doubleword offset).
- R11: funct3 111 depends on `XLEN`. With XLEN=32 it becomes a floating-point word store (opcode 0100111, funct3 010, word offset). With XLEN=64 it becomes an integer doubleword store (opcode 0100011, funct3 011, doubleword offset).
- R12: Whenever `illegal` is 1, `x_instr` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| c_instr | input | 16 | Compressed halfword to expand |
| x_instr | output | 32 | Equivalent base instruction, zero when illegal or outside quadrant 0 |
| illegal | output | 1 | Quadrant-0 encoding is reserved |
| not_q0 | output | 1 | Low two bits of the input are not 00 |

## Verification
The block holds no state, so an internal fault shows at the ports in the same evaluation as the input that exercises it. A mis-wired immediate bit shows up as one wrong bit in the immediate field of every expansion that uses that format. A wrong slot decode shows up as a wrong opcode or funct3. Because the bench sweeps all 65536 halfwords at both widths, every such fault surfaces within one pass.

// File: rtl/rvc_q0_pkg.sv
package rvc_q0_pkg;

  localparam logic [6:0] OPC_OP_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_LOAD     = 7'b0000011;
  localparam logic [6:0] OPC_LOAD_FP  = 7'b0000111;
  localparam logic [6:0] OPC_STORE    = 7'b0100011;
  localparam logic [6:0] OPC_STORE_FP = 7'b0100111;
  localparam logic [2:0] F3_WORD      = 3'b010;
  localparam logic [2:0] F3_DWORD     = 3'b011;
  localparam logic [4:0] SP_REG       = 5'd2;

  typedef enum logic [1:0] {
    K_RSVD  = 2'd0,
    K_ADDSP = 2'd1,
    K_LOAD  = 2'd2,
    K_STORE = 2'd3
  } slot_kind_e;

  typedef struct packed {
    slot_kind_e kind;
    logic [6:0] opc;
    logic [2:0] f3;
    logic       dword_off;
  } slot_t;

  function automatic logic [4:0] widen_reg(input logic [2:0] f);
    return {2'b01, f};
  endfunction

  function automatic logic [11:0] imm_addsp(input logic [15:0] c);
    return {2'b00, c[10:7], c[12:11], c[5], c[6], 2'b00};
  endfunction

  function automatic logic [11:0] imm_word(input logic [15:0] c);
    return {5'b0, c[5], c[12:10], c[6], 2'b00};
  endfunction

  function automatic logic [11:0] imm_dword(input logic [15:0] c);
    return {4'b0, c[6:5], c[12:10], 3'b000};
  endfunction

  function automatic logic [31:0] enc_itype(input logic [11:0] imm, input logic [4:0] rs1,
                                            input logic [2:0] f3, input logic [4:0] rd,
                                            input logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [31:0] enc_stype(input logic [11:0] imm, input logic [4:0] rs2,
                                            input logic [4:0] rs1, input logic [2:0] f3,
                                            input logic [6:0] opc);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
  endfunction

endpackage

// File: rtl/rvc_q0_fields.sv
module rvc_q0_fields
  import rvc_q0_pkg::*;
(
  input  logic [15:0] c_in,
  output logic [4:0]  reg_lo,
  output logic [4:0]  reg_hi,
  output logic [11:0] off_sp,
  output logic [11:0] off_w,
  output logic [11:0] off_d
);
  assign reg_lo = widen_reg(c_in[4:2]);
  assign reg_hi = widen_reg(c_in[9:7]);
  assign off_sp = imm_addsp(c_in);
  assign off_w  = imm_word(c_in);
  assign off_d  = imm_dword(c_in);
endmodule

// File: rtl/rvc_q0_slot_map.sv
module rvc_q0_slot_map
  import rvc_q0_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0] funct3,
  output slot_t      slot
);
  slot_t wide_ld, wide_st;

  generate
    if (XLEN == 64) begin : g_rv64
      assign wide_ld = '{kind: K_LOAD,  opc: OPC_LOAD,  f3: F3_DWORD, dword_off: 1'b1};
      assign wide_st = '{kind: K_STORE, opc: OPC_STORE, f3: F3_DWORD, dword_off: 1'b1};
    end else begin : g_rv32
      assign wide_ld = '{kind: K_LOAD,  opc: OPC_LOAD_FP,  f3: F3_WORD, dword_off: 1'b0};
      assign wide_st = '{kind: K_STORE, opc: OPC_STORE_FP, f3: F3_WORD, dword_off: 1'b0};
    end
  endgenerate

  always_comb begin
    case (funct3)
      3'b000:  slot = '{kind: K_ADDSP, opc: OPC_OP_IMM,   f3: 3'b000,   dword_off: 1'b0};
      3'b001:  slot = '{kind: K_LOAD,  opc: OPC_LOAD_FP,  f3: F3_DWORD, dword_off: 1'b1};
      3'b010:  slot = '{kind: K_LOAD,  opc: OPC_LOAD,     f3: F3_WORD,  dword_off: 1'b0};
      3'b011:  slot = wide_ld;
      3'b101:  slot = '{kind: K_STORE, opc: OPC_STORE_FP, f3: F3_DWORD, dword_off: 1'b1};
      3'b110:  slot = '{kind: K_STORE, opc: OPC_STORE,    f3: F3_WORD,  dword_off: 1'b0};
      3'b111:  slot = wide_st;
      default: slot = '{kind: K_RSVD,  opc: 7'b0,         f3: 3'b000,   dword_off: 1'b0};
    endcase
  end
endmodule

// File: rtl/rvc_q0_expander.sv
module rvc_q0_expander
  import rvc_q0_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [15:0] c_instr,
  output logic [31:0] x_instr,
  output logic        illegal,
  output logic        not_q0
);
  logic [4:0]  reg_lo, reg_hi;
  logic [11:0] off_sp, off_w, off_d, mem_off;
  slot_t       slot;
  logic        in_q0, spn_zero, slot_rsvd;
  logic [31:0] raw_word;

  rvc_q0_fields u_fields (
    .c_in   (c_instr),
    .reg_lo (reg_lo),
    .reg_hi (reg_hi),
    .off_sp (off_sp),
    .off_w  (off_w),
    .off_d  (off_d)
  );

  rvc_q0_slot_map #(.XLEN(XLEN)) u_slot (
    .funct3 (c_instr[15:13]),
    .slot   (slot)
  );

  assign in_q0     = (c_instr[1:0] == 2'b00);
  assign spn_zero  = (slot.kind == K_ADDSP) && (off_sp == 12'd0);
  assign slot_rsvd = (slot.kind == K_RSVD);
  assign mem_off   = slot.dword_off ? off_d : off_w;

  always_comb begin
    case (slot.kind)
      K_ADDSP: raw_word = enc_itype(off_sp, SP_REG, slot.f3, reg_lo, slot.opc);
      K_LOAD:  raw_word = enc_itype(mem_off, reg_hi, slot.f3, reg_lo, slot.opc);
      K_STORE: raw_word = enc_stype(mem_off, reg_lo, reg_hi, slot.f3, slot.opc);
      default: raw_word = 32'd0;
    endcase
  end

  assign not_q0  = !in_q0;
  assign illegal = in_q0 && (slot_rsvd || spn_zero);
  assign x_instr = (in_q0 && !illegal) ? raw_word : 32'd0;
endmodule

// File: rtl/rvc_q0_checker.sv
module rvc_q0_checker (
  input logic [15:0] c_instr,
  input logic [31:0] x_instr,
  input logic        illegal,
  input logic        not_q0
);
  logic [6:0] opc;
  logic       is_store, is_load, is_addi;
  assign opc      = x_instr[6:0];
  assign is_store = (opc == 7'b0100011) || (opc == 7'b0100111);
  assign is_load  = (opc == 7'b0000011) || (opc == 7'b0000111);
  assign is_addi  = (opc == 7'b0010011);

  always_comb begin
    if (not_q0) begin
      a_r1_outside_quiet: assert (x_instr == 32'd0 && !illegal);
    end
    if (illegal) begin
      a_r12_illegal_zero: assert (x_instr == 32'd0 && !not_q0);
    end
    if (c_instr[1:0] == 2'b00 && c_instr[15:13] == 3'b100) begin
      a_r5_slot4_reserved: assert (illegal);
    end
    if (c_instr == 16'd0) begin
      a_r4_all_zero: assert (illegal);
    end
    if (is_addi) begin
      a_r3_addsp_base: assert (x_instr[19:15] == 5'd2 && x_instr[31:20] != 12'd0);
    end
    if (is_load) begin
      a_r2_load_regs: assert (x_instr[11:10] == 2'b01 && x_instr[19:18] == 2'b01);
    end
    if (is_store) begin
      a_r2_store_regs: assert (x_instr[24:23] == 2'b01 && x_instr[19:18] == 2'b01);
    end
  end
endmodule

bind rvc_q0_expander rvc_q0_checker u_chk (
  .c_instr (c_instr),
  .x_instr (x_instr),
  .illegal (illegal),
  .not_q0  (not_q0)
);

// File: tb/tb_rvc_q0_expander.sv
`timescale 1ns/1ps
module tb_rvc_q0_expander;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] c_in = 16'd0;
  logic [31:0] x32, x64;
  logic        ill32, ill64, nq32, nq64;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  rvc_q0_expander #(.XLEN(32)) dut (
    .c_instr(c_in), .x_instr(x32), .illegal(ill32), .not_q0(nq32));
  rvc_q0_expander #(.XLEN(64)) dut64 (
    .c_instr(c_in), .x_instr(x64), .illegal(ill64), .not_q0(nq64));

  // Independent reference: returns {not_q0, illegal, word}
  function automatic logic [33:0] ref_exp(input logic [15:0] c, input bit rv64);
    int unsigned spn, wo, dwo, off, rd_p, rs_p, word, f3;
    int unsigned op, mf3;
    bit store, dsz;
    if (c[1:0] != 2'b00) return {2'b10, 32'd0};                 // R1
    spn = c[10:7] * 64 + c[12:11] * 16 + c[5] * 8 + c[6] * 4;
    wo  = c[5] * 64 + c[12:10] * 8 + c[6] * 4;
    dwo = c[6:5] * 64 + c[12:10] * 8;
    rd_p = 8 + c[4:2];                                          // R2
    rs_p = 8 + c[9:7];
    f3 = c[15:13];
    if (f3 == 4) return {2'b01, 32'd0};                         // R5
    if (f3 == 0) begin
      if (spn == 0) return {2'b01, 32'd0};                      // R4
      word = spn * (1 << 20) + 2 * (1 << 15) + rd_p * 128 + 19;  // R3
      return {2'b00, word[31:0]};
    end
    store = (f3 >= 5);
    case (f3 % 4)
      1: begin op = store ? 39 : 7; dsz = 1; end                 // R8 R9
      2: begin op = store ? 35 : 3; dsz = 0; end                 // R6 R7
      default: begin                                              // R10 R11
        dsz = rv64;
        if (rv64) op = store ? 35 : 3; else op = store ? 39 : 7;
      end
    endcase
    off = dsz ? dwo : wo;
    mf3 = dsz ? 3 : 2;
    if (store)
      word = (off / 32) * (1 << 25) + rd_p * (1 << 20) + rs_p * (1 << 15)
           + mf3 * (1 << 12) + (off % 32) * 128 + op;
    else
      word = off * (1 << 20) + rs_p * (1 << 15) + mf3 * (1 << 12) + rd_p * 128 + op;
    return {2'b00, word[31:0]};
  endfunction

  function automatic string tag_of(input logic [15:0] c, input bit rv64);
    if (c[1:0] != 2'b00) return "R1";
    case (c[15:13])
      3'd0: return "R3/R4";
      3'd1: return "R8";
      3'd2: return "R6";
      3'd3: return rv64 ? "R10(rv64)" : "R10(rv32)";
      3'd4: return "R5";
      3'd5: return "R9";
      3'd6: return "R7";
      default: return rv64 ? "R11(rv64)" : "R11(rv32)";
    endcase
  endfunction

  task automatic compare(input bit rv64, input logic [31:0] x, input logic il, input logic nq,
                         input string extra);
    logic [33:0] e;
    e = ref_exp(c_in, rv64);
    checks++;
    if ({nq, il, x} !== e) begin
      errors++;
      $display("FAIL %s %s in=%h got nq=%b ill=%b x=%h exp nq=%b ill=%b x=%h",
               tag_of(c_in, rv64), extra, c_in, nq, il, x, e[33], e[32], e[31:0]);
    end
    if (il && x !== 32'd0) begin                               // R12
      errors++;
      $display("FAIL R12 in=%h got x=%h exp x=00000000", c_in, x);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: all-zero halfword is illegal (R4)
    @(negedge clk);
    compare(1'b0, x32, ill32, nq32, "idle R4");
    // directed R2: rd'=7, rs1'=0 word load -> rd x15, rs1 x8
    @(posedge clk); c_in = 16'b010_000_000_00_111_00;
    @(negedge clk);
    compare(1'b0, x32, ill32, nq32, "R2 corners");
    checks++;
    if (x32[11:7] !== 5'd15 || x32[19:15] !== 5'd8) begin
      errors++;
      $display("FAIL R2 got rd=%0d rs1=%0d exp rd=15 rs1=8", x32[11:7], x32[19:15]);
    end
    // exhaustive sweep at both widths
    for (int i = 0; i < 65536; i++) begin
      @(posedge clk); c_in = i[15:0];
      @(negedge clk);
      compare(1'b0, x32, ill32, nq32, "sweep");
      compare(1'b1, x64, ill64, nq64, "sweep");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule